// File: doc/BRIEF.md
# Inhibitable Angle Output Latch

This block sits between a tracking converter's position counter and a 16-bit parallel data bus. It keeps a copy of the counter angle and presents it on the bus. Before the copy is stored, the angle is trimmed to the selected resolution. The copy follows the counter on every clock unless the host freezes it with an active-low inhibit, or unless the counter is in the middle of an update. The counter itself is not affected by the inhibit and keeps tracking. Any steps taken while the inhibit is held show up in the copy on the first clock after the inhibit is released.

The bus is split into an upper byte and a lower byte. Each byte has its own active-low enable. The tri-state bus is modelled by two outputs: a data value, and a per-byte output-enable vector. A byte that is not enabled reports a cleared output enable and drives zeros on its data lines. Bus electrical timing is not modelled. Each capture takes effect one clock after its conditions are met.

Bit numbering on the bus puts the most significant bit at port bit 15.

Top module: `angle_output_latch`

## Requirements
- R1: While `inh_n` is 1 and `busy` is 0 at a rising clock edge, the held word after that edge equals `cnt_val` as it was at that edge, with resolution masking applied.
- R2: While `inh_n` is 0 at a rising clock edge, the held word does not change, whatever `cnt_val` does.
- R3: After `inh_n` returns to 1, the first edge with `busy` at 0 loads the counter value present at that edge. This includes any changes the counter made while the word was inhibited.
- R4: `res_code` selects the resolution: 0 gives 10 bits, 1 gives 12 bits, 2 gives 14 bits and 3 gives 16 bits. Unused bits are cleared in pairs from the least significant end. At code 2, bits [1:0] are 0. At code 1, bits [3:0] are 0. At code 0, bits [5:0] are 0.
- R5: While `busy` is 1 at a rising edge, the held word does not change. The first edge after `busy` falls (with `inh_n` at 1) loads the new counter value.
- R6: When `msb_en_n` is 0, `byte_oe[1]` is 1 and `bus_q[15:8]` shows the upper byte of the held word. When `msb_en_n` is 1, `byte_oe[1]` is 0 and `bus_q[15:8]` is 0. Both outputs react without waiting for a clock.
- R7: When `lsb_en_n` is 0, `byte_oe[0]` is 1 and `bus_q[7:0]` shows the lower byte of the held word. When `lsb_en_n` is 1, `byte_oe[0]` is 0 and `bus_q[7:0]` is 0. Both outputs react without waiting for a clock.
- R8: While `rst_n` is 0, the held word is 0.
- R9: Masking uses the resolution code present at the capture edge. Changing `res_code` while the word is inhibited leaves the presented word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| cnt_val | input | 16 | Live angle from the tracking counter, most significant bit at 15 |
| res_code | input | 2 | Resolution select: 0=10, 1=12, 2=14, 3=16 bits |
| busy | input | 1 | High while the counter is being updated |
| inh_n | input | 1 | Active-low freeze of the held word |
| msb_en_n | input | 1 | Active-low enable of the upper byte |
| lsb_en_n | input | 1 | Active-low enable of the lower byte |
| bus_q | output | 16 | Bus data; a disabled byte reads 0 |
| byte_oe | output | 2 | Per-byte drive enable: bit 1 for the upper byte, bit 0 for the lower byte |

## Verification
Each of the four resolution codes is tried with an all-ones word and with two mixed words. The all-ones word shows exactly which pairs are cleared. The mixed words show that the retained bits pass through without being reordered. Counter changes are applied while the inhibit is held, while the busy strobe is high, and on the release edge. These cases separate three behaviours: a latch that freezes, a latch that keeps following, and a latch that reloads late. The byte enables are toggled one at a time against a word whose two bytes differ, so a swapped enable shows up as a wrong byte.

// File: rtl/angle_latch_pkg.sv
package angle_latch_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned MIN_RES = 10;
  localparam int unsigned CODE_W  = 2;
endpackage

// File: rtl/angle_res_mask.sv
module angle_res_mask #(
  parameter int unsigned WORD_W  = angle_latch_pkg::WORD_W,
  parameter int unsigned MIN_RES = angle_latch_pkg::MIN_RES,
  parameter int unsigned CODE_W  = angle_latch_pkg::CODE_W
) (
  input  logic [CODE_W-1:0] res_code,
  input  logic [WORD_W-1:0] raw_word,
  output logic [WORD_W-1:0] masked_word
);
  // Count of optional bit pairs below the always-kept upper bits.
  localparam int unsigned NPAIR = (WORD_W - MIN_RES) / 2;

  // The upper MIN_RES bits are kept at every resolution.
  assign masked_word[WORD_W-1 -: MIN_RES] = raw_word[WORD_W-1 -: MIN_RES];

  // Pair g (g=0 is the lowest pair) is kept only when the code reaches NPAIR-g.
  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    localparam logic [CODE_W-1:0] KEEP_AT = CODE_W'(NPAIR - g);
    assign masked_word[2*g+1 -: 2] = (res_code >= KEEP_AT) ? raw_word[2*g+1 -: 2] : 2'b00;
  end
endmodule

// File: rtl/angle_hold_reg.sv
module angle_hold_reg #(
  parameter int unsigned WORD_W = angle_latch_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inh_n,
  input  logic              busy,
  input  logic [WORD_W-1:0] new_word,
  output logic [WORD_W-1:0] held_word
);
  logic              cap_en;
  logic [WORD_W-1:0] word_d;
  logic [WORD_W-1:0] word_q;

  // Capture only when not inhibited and the counter is settled.
  always_comb begin
    cap_en = inh_n & ~busy;
    word_d = word_q;
    if (cap_en) word_d = new_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign held_word = word_q;
endmodule

// File: rtl/angle_byte_drive.sv
module angle_byte_drive #(
  parameter int unsigned WORD_W = angle_latch_pkg::WORD_W,
  parameter int unsigned BYTE_W = angle_latch_pkg::BYTE_W,
  localparam int unsigned NBYTE = WORD_W / BYTE_W
) (
  input  logic [WORD_W-1:0] held_word,
  input  logic [NBYTE-1:0]  en_n,
  output logic [WORD_W-1:0] bus_q,
  output logic [NBYTE-1:0]  byte_oe
);
  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    assign byte_oe[b] = ~en_n[b];
    assign bus_q[b*BYTE_W +: BYTE_W] = en_n[b] ? '0 : held_word[b*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/angle_output_latch.sv
module angle_output_latch #(
  parameter int unsigned WORD_W  = angle_latch_pkg::WORD_W,
  parameter int unsigned BYTE_W  = angle_latch_pkg::BYTE_W,
  parameter int unsigned MIN_RES = angle_latch_pkg::MIN_RES,
  parameter int unsigned CODE_W  = angle_latch_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cnt_val,
  input  logic [CODE_W-1:0] res_code,
  input  logic              busy,
  input  logic              inh_n,
  input  logic              msb_en_n,
  input  logic              lsb_en_n,
  output logic [WORD_W-1:0] bus_q,
  output logic [1:0]        byte_oe
);
  logic [WORD_W-1:0] masked_word;
  logic [WORD_W-1:0] hold_word;

  angle_res_mask #(.WORD_W(WORD_W), .MIN_RES(MIN_RES), .CODE_W(CODE_W)) mask_i (
    .res_code    (res_code),
    .raw_word    (cnt_val),
    .masked_word (masked_word)
  );

  angle_hold_reg #(.WORD_W(WORD_W)) hold_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .inh_n     (inh_n),
    .busy      (busy),
    .new_word  (masked_word),
    .held_word (hold_word)
  );

  // Two byte lanes: index 1 is the upper byte, index 0 the lower byte.
  angle_byte_drive #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) drive_i (
    .held_word (hold_word),
    .en_n      ({msb_en_n, lsb_en_n}),
    .bus_q     (bus_q),
    .byte_oe   (byte_oe)
  );
endmodule

// File: rtl/angle_latch_chk.sv
module angle_latch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cnt_val,
  input logic [1:0]  res_code,
  input logic        busy,
  input logic        inh_n,
  input logic        msb_en_n,
  input logic        lsb_en_n,
  input logic [15:0] bus_q,
  input logic [1:0]  byte_oe,
  input logic [15:0] hold_word
);
  a_r1_track: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_n && !busy && res_code == 2'd3) |=> hold_word == $past(cnt_val));

  a_r2_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !inh_n |=> $stable(hold_word));

  a_r4_mask10: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_n && !busy && res_code == 2'd0) |=> hold_word[5:0] == 6'd0);

  a_r5_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(hold_word));

  a_r6_msb_off: assert property (@(posedge clk) disable iff (!rst_n)
    msb_en_n |-> (!byte_oe[1] && bus_q[15:8] == 8'd0));

  a_r7_lsb_on: assert property (@(posedge clk) disable iff (!rst_n)
    !lsb_en_n |-> (byte_oe[0] && bus_q[7:0] == hold_word[7:0]));
endmodule

bind angle_output_latch angle_latch_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_val   (cnt_val),
  .res_code  (res_code),
  .busy      (busy),
  .inh_n     (inh_n),
  .msb_en_n  (msb_en_n),
  .lsb_en_n  (lsb_en_n),
  .bus_q     (bus_q),
  .byte_oe   (byte_oe),
  .hold_word (hold_word)
);

// File: tb/angle_output_latch_tb.sv
module angle_output_latch_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [15:0] cnt_val;
  logic [1:0]  res_code;
  logic        busy;
  logic        inh_n;
  logic        msb_en_n;
  logic        lsb_en_n;
  logic [15:0] bus_q;
  logic [1:0]  byte_oe;

  int total_cnt = 0;
  int bad_cnt   = 0;
  bit run_done  = 0;

  angle_output_latch dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .res_code(res_code),
    .busy(busy), .inh_n(inh_n), .msb_en_n(msb_en_n), .lsb_en_n(lsb_en_n),
    .bus_q(bus_q), .byte_oe(byte_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] exp_mask(input logic [15:0] v, input logic [1:0] code);
    int keep;
    logic [15:0] lowm;
    keep = 10 + 2 * int'(code);
    lowm = (16'd1 << (16 - keep)) - 16'd1;
    return v & ~lowm;
  endfunction

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    total_cnt++;
    if (act !== exp) begin
      bad_cnt++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One full clock: returns just after the next falling edge.
  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cnt_val = 16'hFFFF; res_code = 2'd3; busy = 1'b0;
    inh_n = 1'b1; msb_en_n = 1'b0; lsb_en_n = 1'b0;
    repeat (3) step();
    check("R8 reset word", {byte_oe, bus_q}, {2'b11, 16'h0000});
    rst_n = 1'b1;
  endtask

  task automatic t_follow();
    logic [15:0] pats [3] = '{16'hFFFF, 16'hA5C3, 16'h1234};
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 3; p++) begin
        res_code = 2'(c);
        cnt_val  = pats[p];
        step();
        check($sformatf("R1 R4 follow code%0d", c), {2'b11, bus_q},
              {2'b11, exp_mask(pats[p], 2'(c))});
      end
    end
  endtask

  task automatic t_inhibit();
    res_code = 2'd3; cnt_val = 16'h1357; step();
    inh_n = 1'b0; cnt_val = 16'hBEEF; step();
    check("R2 freeze first", {2'b11, bus_q}, {2'b11, 16'h1357});
    cnt_val = 16'h4444; step();
    check("R2 freeze second", {2'b11, bus_q}, {2'b11, 16'h1357});
  endtask

  task automatic t_release();
    cnt_val = 16'h9ABC; step();
    check("R3 still held", {2'b11, bus_q}, {2'b11, 16'h1357});
    inh_n = 1'b1; step();
    check("R3 reload on release", {2'b11, bus_q}, {2'b11, 16'h9ABC});
  endtask

  task automatic t_busy();
    cnt_val = 16'h1111; step();
    busy = 1'b1; cnt_val = 16'h2222; step();
    check("R5 hold while busy", {2'b11, bus_q}, {2'b11, 16'h1111});
    busy = 1'b0; step();
    check("R5 load after busy", {2'b11, bus_q}, {2'b11, 16'h2222});
  endtask

  task automatic t_res_hold();
    res_code = 2'd3; cnt_val = 16'hFFFF; step();
    inh_n = 1'b0; res_code = 2'd0; step();
    check("R9 code change while held", {2'b11, bus_q}, {2'b11, 16'hFFFF});
    inh_n = 1'b1; step();
    check("R9 R4 mask on next capture", {2'b11, bus_q}, {2'b11, 16'hFFC0});
  endtask

  task automatic t_enables();
    res_code = 2'd3; cnt_val = 16'hA55A; step();
    msb_en_n = 1'b1; #1;
    check("R6 upper byte off", {byte_oe, bus_q}, {2'b01, 16'h005A});
    msb_en_n = 1'b0; lsb_en_n = 1'b1; #1;
    check("R7 lower byte off", {byte_oe, bus_q}, {2'b10, 16'hA500});
    msb_en_n = 1'b1; #1;
    check("R6 R7 both off", {byte_oe, bus_q}, {2'b00, 16'h0000});
    msb_en_n = 1'b0; lsb_en_n = 1'b0; #1;
    check("R6 R7 both on", {byte_oe, bus_q}, {2'b11, 16'hA55A});
  endtask

  initial begin
    t_reset();
    step();
    t_follow();
    t_inhibit();
    t_release();
    t_busy();
    t_res_hold();
    t_enables();
    run_done = 1;
    $display("  test done: total=%0d bad=%0d", total_cnt, bad_cnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!run_done) begin
      total_cnt++;
      bad_cnt++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total_cnt, bad_cnt);
      $finish;
    end
  end
endmodule